// File: doc/BRIEF.md
# Touch conversion sequencer with pen interrupt

This block sequences touchscreen and auxiliary-channel conversions on behalf of a host. The host writes a control word that picks the next scan function, a result resolution, a filter field, a host-mode flag and a stop bit. Whenever the chosen function and the current pen state allow it, the block goes busy for a fixed number of clock cycles. It then raises the data-available bits that belong to that function in an 11-bit mask.

The host reads results through a small register window. A data page holds one result register per channel, and a control page holds the control word and a status word. The conversion itself is not modelled. Raw 16-bit results arrive on an input bus and are right-shifted to the resolution that was latched when the conversion started. Reading a result register clears its data-available bit.

An interrupt pin reports one of three conditions, chosen by a two-bit pin-function field: pen pressed, data pending, or pen pressed with nothing pending. The pin is held low while the block is disabled. The start and self-disable conditions are evaluated on every clock cycle from registered state. The pen input passes through one register before it is used.

Top module: `touch_conv_seq`

## Requirements
- R1: At the end of a conversion the mask gains the bits of the latched function: 1→0x0600, 2→0x0780, 3→0x0400, 4→0x0200, 5→0x0180, 6→0x0040, 7→0x0030, 8 and 9→0x0010, 10→0x0004, 11→0x0070, 12→0x0002. Functions 0, 13, 14 and 15 never start a conversion.
- R2: Reading a data-page register clears one mask bit: register 0 clears bit 10, 1 clears bit 9, 2 clears bit 8, 3 clears bit 7, and registers 5..11 clear bits 6..0 in turn. Register 4 and registers 12..15 clear nothing and read 0xFFFF. When a clear and a completion land on the same edge, the set wins.
- R3: Functions 1 to 5 start only while the registered pen is pressed.
- R4: Functions 3 to 8, 10 and 12 are single-shot. For these, a non-empty mask blocks any start and clears enable (functions 3 to 5 do so only while the pen is pressed). Functions 9 and 11, and 1 and 2 while the pen is pressed, restart after every conversion.
- R5: The pin is high for pin function 0 when the pen is pressed, for 1 when any mask bit is set, and for 2 or 3 when the pen is pressed and the mask is empty. The pin is low while the block is disabled.
- R6: A write to control-page register 0 loads host mode from bit 15, enable as the inverse of bit 14, the next function from bits 13:10, the next resolution from 9:8 and the filter from 7:0. If bit 14 is set, any conversion in progress is aborted without setting mask bits.
- R7: Control-page register 0 reads {pen, not-busy, next function[3:0], next resolution[1:0], filter[7:0]}, most significant bit first.
- R8: Control-page register 1 reads {pin function[1:0], not-enabled, host mode, any-mask-bit, mask[10:0]}. Writing it loads the pin function from bits 15:14. Control-page registers 2..15 read 0xFFFF.
- R9: A data register in 0..11 other than 4 returns its 16-bit input channel shifted right by 4, 8, 6 or 4 for resolution codes 0, 1, 2 and 3. The code used is the one latched at the start of the most recent conversion.
- R10: A conversion starts on the first clock edge at which registered state allows it. It keeps the block busy for exactly CONV_CYCLES cycles, and its mask bits appear on the edge that ends the busy period.
- R11: After reset the control word reads 0x4000, the status word reads 0xA000 (pin function 2, disabled) and the pin is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pen_down | input | 1 | Pen pressed level |
| conv_data | input | 192 | Raw 16-bit results, channel n at bits 16n+15:16n |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_page | input | 1 | 0 selects data page, 1 selects control page |
| reg_addr | input | 4 | Register index within the page |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register, combinational |
| pen_irq | output | 1 | Interrupt pin |

## Verification
The bench builds the block with CONV_CYCLES set to 8. A full conversion plus margin then takes about a dozen cycles, so it can count the busy window cycle by cycle and run every one of the sixteen scan functions under random pen state, resolution and channel data. That short window also keeps the stop-during-busy abort and the restart of continuous functions within a few cycles of the stimulus.

// File: rtl/touch_conv_seq.sv
`timescale 1ns/1ps
module touch_conv_seq #(
  parameter int CONV_CYCLES = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pen_down,
  input  logic [191:0] conv_data,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic         reg_page,
  input  logic [3:0]   reg_addr,
  input  logic [15:0]  reg_wdata,
  output logic [15:0]  reg_rdata,
  output logic         pen_irq
);
  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;

  logic             pen_q, en_q, host_q, busy_q;
  logic [3:0]       nfn_q, fn_q;
  logic [1:0]       nres_q, res_q, pin_fn_q;
  logic [7:0]       filt_q;
  logic [10:0]      dav_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [10:0] fn_mask(input logic [3:0] f);
    case (f)
      4'd1:       fn_mask = 11'h600;
      4'd2:       fn_mask = 11'h780;
      4'd3:       fn_mask = 11'h400;
      4'd4:       fn_mask = 11'h200;
      4'd5:       fn_mask = 11'h180;
      4'd6:       fn_mask = 11'h040;
      4'd7:       fn_mask = 11'h030;
      4'd8, 4'd9: fn_mask = 11'h010;
      4'd10:      fn_mask = 11'h004;
      4'd11:      fn_mask = 11'h070;
      4'd12:      fn_mask = 11'h002;
      default:    fn_mask = 11'h000;
    endcase
  endfunction

  function automatic logic [3:0] res_shift(input logic [1:0] r);
    case (r)
      2'd1:    res_shift = 4'd8;
      2'd2:    res_shift = 4'd6;
      default: res_shift = 4'd4;
    endcase
  endfunction

  wire any_dav = |dav_q;
  wire ctrl_wr = reg_wr && reg_page && (reg_addr == 4'd0);
  wire stat_wr = reg_wr && reg_page && (reg_addr == 4'd1);
  wire data_rd = reg_rd && !reg_page;

  wire runs   = (nfn_q >= 4'd1) && (nfn_q <= 4'd12);
  wire gated  = (nfn_q >= 4'd1) && (nfn_q <= 4'd5);
  wire single = ((nfn_q >= 4'd3) && (nfn_q <= 4'd8)) || (nfn_q == 4'd10) || (nfn_q == 4'd12);
  wire pen_ok = !gated || pen_q;

  wire start    = en_q && !busy_q && runs && pen_ok && !(single && any_dav);
  wire self_off = en_q && single && pen_ok && any_dav;
  wire done     = busy_q && (cnt_q == '0);

  logic [10:0] rd_clr;
  always_comb begin
    rd_clr = '0;
    if (data_rd) begin
      if (reg_addr < 4'd4)
        rd_clr[4'd10 - reg_addr] = 1'b1;
      else if (reg_addr > 4'd4 && reg_addr < 4'd12)
        rd_clr[4'd11 - reg_addr] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pen_q    <= 1'b0;
      en_q     <= 1'b0;
      host_q   <= 1'b0;
      busy_q   <= 1'b0;
      nfn_q    <= '0;
      fn_q     <= '0;
      nres_q   <= '0;
      res_q    <= '0;
      pin_fn_q <= 2'd2;
      filt_q   <= '0;
      dav_q    <= '0;
      cnt_q    <= '0;
    end else begin
      pen_q <= pen_down;
      dav_q <= (dav_q & ~rd_clr) | (done ? fn_mask(fn_q) : 11'h000);
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(CONV_CYCLES - 1);
        fn_q   <= nfn_q;
        res_q  <= nres_q;
      end else if (done) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (self_off) en_q <= 1'b0;
      if (ctrl_wr) begin
        host_q <= reg_wdata[15];
        en_q   <= !reg_wdata[14];
        nfn_q  <= reg_wdata[13:10];
        nres_q <= reg_wdata[9:8];
        filt_q <= reg_wdata[7:0];
        if (reg_wdata[14]) busy_q <= 1'b0;
      end
      if (stat_wr) pin_fn_q <= reg_wdata[15:14];
    end
  end

  wire [15:0] chan = conv_data[{reg_addr, 4'b0000} +: 16];

  always_comb begin
    if (!reg_page) begin
      if (reg_addr == 4'd4 || reg_addr > 4'd11) reg_rdata = 16'hFFFF;
      else reg_rdata = chan >> res_shift(res_q);
    end else begin
      case (reg_addr)
        4'd0:    reg_rdata = {pen_q, !busy_q, nfn_q, nres_q, filt_q};
        4'd1:    reg_rdata = {pin_fn_q, !en_q, host_q, any_dav, dav_q};
        default: reg_rdata = 16'hFFFF;
      endcase
    end
  end

  always_comb begin
    case (pin_fn_q)
      2'd0:    pen_irq = en_q && pen_q;
      2'd1:    pen_irq = en_q && any_dav;
      default: pen_irq = en_q && pen_q && !any_dav;
    endcase
  end
endmodule

// File: rtl/touch_conv_seq_chk.sv
`timescale 1ns/1ps
module touch_conv_seq_chk #(
  parameter int CONV_CYCLES = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        en_q,
  input logic        busy_q,
  input logic [3:0]  fn_q,
  input logic [10:0] dav_q,
  input logic        pen_irq,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic        reg_page,
  input logic [3:0]  reg_addr,
  input logic [15:0] reg_wdata
);
  int run_len;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy_q) run_len <= 0;
    else run_len <= run_len + 1;
  end

  wire stop_wr = reg_wr && reg_page && (reg_addr == 4'd0) && reg_wdata[14];

  AST_MASK_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    ((dav_q & ~$past(dav_q)) != 11'h000) |-> $past(busy_q)); // R1
  AST_IDLE_FUNCTIONS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (fn_q != 4'd0 && fn_q < 4'd13)); // R1
  AST_READ_CLEARS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_rd && !reg_page && reg_addr == 4'd0) && !$past(busy_q)) |-> !dav_q[10]); // R2
  AST_STOP_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_wr) |-> (!busy_q && !en_q)); // R6
  AST_PIN_LOW_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !pen_irq); // R5
  AST_CONV_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && !$past(stop_wr)) |-> ($past(run_len) == CONV_CYCLES - 1)); // R10
endmodule

bind touch_conv_seq touch_conv_seq_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .busy_q(busy_q), .fn_q(fn_q),
  .dav_q(dav_q), .pen_irq(pen_irq), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_page(reg_page), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/touch_conv_seq_test.sv
`timescale 1ns/1ps
module touch_conv_seq_test;
  localparam int CC = 8;

  logic         clk = 1'b0;
  logic         rst_n, pen_down, reg_wr, reg_rd, reg_page;
  logic [191:0] conv_data;
  logic [3:0]   reg_addr;
  logic [15:0]  reg_wdata, reg_rdata;
  logic         pen_irq;

  always #4 clk = ~clk;

  touch_conv_seq #(.CONV_CYCLES(CC)) uut (
    .clk(clk), .rst_n(rst_n), .pen_down(pen_down), .conv_data(conv_data),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_page(reg_page), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pen_irq(pen_irq)
  );

  int errs = 0, checks = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mask_of(input int m);
    case (m)
      1: return 16'h0600;  2: return 16'h0780;  3: return 16'h0400;
      4: return 16'h0200;  5: return 16'h0180;  6: return 16'h0040;
      7: return 16'h0030;  8, 9: return 16'h0010; 10: return 16'h0004;
      11: return 16'h0070; 12: return 16'h0002;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic int shift_of(input int r);
    return (r == 1) ? 8 : (r == 2) ? 6 : 4;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit pg, input int a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_page = pg; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input bit pg, input int a, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_page = pg; reg_addr = 4'(a);
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input bit pg, input int a, output logic [15:0] d);
    reg_page = pg; reg_addr = 4'(a);
    #1 d = reg_rdata;
  endtask

  task automatic set_pen(input bit p);
    pen_down = p;
    cyc(2);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int n, exp_res;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; pen_down = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    reg_page = 1'b0; reg_addr = '0; reg_wdata = '0; conv_data = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R11 reset state
    rd(1, 0, d); chk("R11 ctrl", d, 16'h4000);
    rd(1, 1, d); chk("R11 status", d, 16'hA000);
    chk("R11 pin", pen_irq, 0);

    // R7 control readback, R8 status and pin-function write
    wr(1, 0, 16'h81A5);
    rd(1, 0, d); chk("R7 ctrl readback", d, 16'h41A5);
    rd(1, 1, d); chk("R8 status host", d, 16'h9000);
    wr(1, 1, 16'h4000);
    rd(1, 1, d); chk("R8 pin fn write", d, 16'h5000);
    wr(1, 1, 16'h8000);

    // R10 busy window length, R1 mask, R4 single-shot disable
    conv_data[5*16 +: 16] = 16'hABCD;
    wr(1, 0, 16'h1900);
    n = 0;
    repeat (CC + 6) begin
      peek(1, 0, d);
      if (!d[14]) n++;
      @(negedge clk);
    end
    chk("R10 busy cycles", n, CC);
    rd(1, 1, d); chk("R1 R4 status after fn6", d, 16'hA840);

    // R9 resolution latched at start
    rd(0, 5, d); chk("R9 res1", d, 16'h00AB);
    wr(1, 0, 16'h4200);
    rd(0, 5, d); chk("R9 latched res", d, 16'h00AB);
    rd(1, 0, d); chk("R7 next res", d, 16'h4200);
    rd(1, 1, d); chk("R2 cleared", d, 16'hA000);

    // R3 pen gating
    set_pen(0);
    wr(1, 0, 16'h0C00);
    cyc(CC + 4);
    rd(1, 1, d); chk("R3 no pen", d, 16'h8000);
    set_pen(1);
    cyc(CC + 4);
    rd(1, 1, d); chk("R3 pen", d, 16'hAC00);
    rd(0, 0, d);

    // R2 clear mapping
    wr(1, 0, 16'h0800);
    cyc(CC + 4);
    wr(1, 0, 16'h4000);
    rd(1, 1, d); chk("R2 fn2 mask", d, 16'hAF80);
    rd(0, 1, d);
    rd(1, 1, d); chk("R2 reg1 clears bit9", d, 16'hAD80);
    rd(0, 4, d); chk("R2 reg4 value", d, 16'hFFFF);
    rd(1, 1, d); chk("R2 reg4 no clear", d, 16'hAD80);
    rd(0, 3, d);
    rd(1, 1, d); chk("R2 reg3 clears bit7", d, 16'hAD00);
    rd(0, 0, d); rd(0, 2, d);
    rd(1, 1, d); chk("R2 all clear", d, 16'hA000);

    // R5 pin functions
    wr(1, 1, 16'h0000);
    chk("R5 disabled low", pen_irq, 0);
    wr(1, 0, 16'h0000);
    chk("R5 fn0 pen", pen_irq, 1);
    set_pen(0);
    chk("R5 fn0 no pen", pen_irq, 0);
    wr(1, 1, 16'h8000);
    set_pen(1);
    chk("R5 fn2 pen no data", pen_irq, 1);
    wr(1, 0, 16'h2400);
    cyc(CC + 4);
    chk("R5 fn2 data pending", pen_irq, 0);
    wr(1, 1, 16'h4000);
    chk("R5 fn1 data", pen_irq, 1);

    // R4 continuous restart
    rd(0, 7, d);
    cyc(CC + 4);
    rd(1, 1, d); chk("R4 continuous", d, 16'h4810);

    // R6 stop aborts
    wr(1, 0, 16'h4000);
    chk("R5 stop forces low", pen_irq, 0);
    rd(0, 7, d);
    wr(1, 0, 16'h1800);
    cyc(3);
    wr(1, 0, 16'h4000);
    cyc(CC + 4);
    rd(1, 1, d); chk("R6 abort no data", d, 16'h6000);
    rd(1, 0, d); chk("R6 not busy", d, 16'hC000);
    wr(1, 1, 16'h8000);

    // Random sweep: R1 R3 R4 R7 R9 R2
    exp_res = 0;
    for (int it = 0; it < 40; it++) begin
      int m, r, p, f;
      bit started, single;
      logic [15:0] e;
      m = $urandom % 16; r = $urandom % 4; p = $urandom % 2; f = $urandom % 256;
      for (int i = 0; i < 12; i++) conv_data[i*16 +: 16] = 16'($urandom);
      set_pen(p[0]);
      wr(1, 0, {2'b00, 4'(m), 2'(r), 8'(f)});
      started = (m >= 1 && m <= 12) && (m > 5 || p == 1);
      single  = (m >= 3 && m <= 8) || m == 10 || m == 12;
      if (started) exp_res = r;
      cyc(CC + 6);
      rd(1, 0, d); chk("R7 random fields", d[13:0], {4'(m), 2'(r), 8'(f)});
      e = 16'h8000 | ((started && single) ? 16'h2000 : 16'h0000) |
          (started ? (16'h0800 | mask_of(m)) : 16'h0000);
      rd(1, 1, d); chk("R1 R3 R4 random status", d, e);
      wr(1, 0, 16'h4000);
      for (int k = 0; k < 12; k++) begin
        rd(0, k, d);
        e = (k == 4) ? 16'hFFFF : (conv_data[k*16 +: 16] >> shift_of(exp_res));
        chk("R9 random data", d, e);
      end
      rd(1, 1, d); chk("R2 random cleared", d, 16'hA000);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule